// File: doc/BRIEF.md
# Processor Interrupt Entry Sequencer

This control unit sits inside a 16-bit segmented processor core. It looks at every instruction boundary and decides whether an interrupt is to be taken. If so, it picks the winning source and forms that source's 8-bit type number. It then carries out the entry sequence on a word-wide memory port. The sequence saves the flags, code segment and instruction pointer on the stack, then fetches the new instruction pointer and code segment from the vector table. On a separate request it performs the matching return sequence, which restores the three saved words.

The core reports the instruction boundary, the halt state, the current flags word and its segment and pointer registers. The sequencer reports the new register values with a one-cycle done strobe. The core stalls for the whole time `busy` is high. For the maskable request, the sequencer runs the two-pulse acknowledge handshake and reads the type number from the external type bus.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy`, `memReq`, `entryDone` and `retDone` are low and `intaN` is high.
- R2: At a boundary (`bndry` high, `haltIn` low), one source at most is taken, in this order from highest to lowest: divide error (type 0), INTO with overflow (type 4), software request (type `swType`), pending NMI (type 2), maskable request, trap flag (type 1).
- R3: A rising edge on `nmiPin` is latched whatever the value of IF. The latch clears when an NMI entry starts. A rising edge that arrives while a sequence is running is latched again and taken at a later boundary.
- R4: `intrPin` is level sensitive. It is looked at only in a cycle where a decision is made, and it is honoured only when IF (flags bit 9) is 1.
- R5: A maskable entry drives `intaN` low for exactly two single-cycle pulses separated by one high cycle, with no memory request during them. The type is taken from `typeBus` in the cycle of the second pulse.
- R6: The vector reads use address type×4 for the new IP and type×4+2 for the new CS.
- R7: The entry issues five accesses in this order: write the original flags, write CS, write IP, read the IP vector, read the CS vector. `newFlags` equals the saved flags with IF (bit 9) and TF (bit 8) cleared.
- R8: TF set (bit 8) raises type 1 after an instruction. INTO raises type 4 only when OF (bit 11) is 1, and otherwise starts no sequence.
- R9: Stack addresses are SS×16+SP. SP drops by 2 before each push and rises by 2 after each pop. `newSp` returns the final value.
- R10: Once raised, `memReq`, `memWe`, `memAddr` and `memWdata` hold steady until `memAck` is seen high at a clock edge.
- R11: `iretReq` in an idle cycle starts a return, which takes precedence over a boundary in the same cycle. The return reads IP at SS×16+SP, then CS, then the flags from the next two words. It then pulses `retDone` with `newSp` equal to SP+6.
- R12: While `haltIn` is high, only a pending NMI or an enabled maskable request starts an entry, and it does so in any cycle without `bndry`. Divide, INTO, software and trap sources are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bndry | input | 1 | Last clock of an instruction |
| haltIn | input | 1 | Core is halted |
| iretReq | input | 1 | Start the return sequence |
| nmiPin | input | 1 | Non-maskable request, rising edge |
| intrPin | input | 1 | Maskable request, level |
| divErr | input | 1 | Divide error in this instruction |
| intoExec | input | 1 | INTO executed in this instruction |
| swReq | input | 1 | Software interrupt instruction |
| swType | input | 8 | Type of the software interrupt |
| flagsIn | input | 16 | Current flags word |
| ssIn | input | 16 | Stack segment |
| spIn | input | 16 | Stack pointer |
| csIn | input | 16 | Code segment |
| ipIn | input | 16 | Return instruction pointer |
| typeBus | input | 8 | Type number from the external controller |
| intaN | output | 1 | Acknowledge, active low |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write |
| memAddr | output | 20 | Byte address |
| memWdata | output | 16 | Write data |
| memAck | input | 1 | Access completes this cycle |
| memRdata | input | 16 | Read data, valid with memAck |
| busy | output | 1 | A sequence is running |
| entryDone | output | 1 | Entry finished, new values valid |
| retDone | output | 1 | Return finished, new values valid |
| typeOut | output | 8 | Type number taken |
| newCs | output | 16 | New code segment |
| newIp | output | 16 | New instruction pointer |
| newSp | output | 16 | New stack pointer |
| newFlags | output | 16 | New flags word |

## Verification
The hardest cases to reach are the ones that depend on history. One is an NMI edge that lost arbitration, or that arrived in the middle of a running sequence, and must still be taken at a later boundary. The other is a type number that must be taken from the second acknowledge pulse and not the first. The stimulus pulses `nmiPin` during busy sequences and mixes random sets of sources at boundaries, while a bench model carries the pending NMI forward. The type bus responder presents a wrong value everywhere except in the second pulse. Memory acknowledges come after random stalls, so the held-request rule is exercised on every access.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int TYPE_W = 8;
  localparam int IF_POS = 9;
  localparam int TF_POS = 8;
  localparam int OF_POS = 11;
  localparam logic [TYPE_W-1:0] TYPE_DIV  = 8'd0;
  localparam logic [TYPE_W-1:0] TYPE_STEP = 8'd1;
  localparam logic [TYPE_W-1:0] TYPE_NMI  = 8'd2;
  localparam logic [TYPE_W-1:0] TYPE_OVF  = 8'd4;

  typedef enum logic [1:0] {A_PUSH, A_POP, A_VLO, A_VHI} addrSel_e;
  typedef enum logic [1:0] {W_FLAGS, W_CS, W_IP} wdSel_e;

  typedef struct packed {
    logic              capCtx;
    logic              ldType;
    logic [TYPE_W-1:0] typeVal;
    logic              capBus;
    addrSel_e          addrSel;
    wdSel_e            wdSel;
    logic              spDown;
    logic              spUp;
    logic              ldIp;
    logic              ldCs;
    logic              ldFlags;
  } dpStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bndry,
  input  logic              haltIn,
  input  logic              iretReq,
  input  logic              nmiPin,
  input  logic              intrPin,
  input  logic              divErr,
  input  logic              intoExec,
  input  logic              swReq,
  input  logic [TYPE_W-1:0] swType,
  input  logic              flagIf,
  input  logic              flagTf,
  input  logic              flagOf,
  input  logic              memAck,
  output logic              memReq,
  output logic              memWe,
  output logic              intaN,
  output logic              busy,
  output logic              entryDone,
  output logic              retDone,
  output dpStrobe_t         st
);
  typedef enum logic [3:0] {
    S_IDLE, S_INTA1, S_GAP, S_INTA2, S_PUSHF, S_PUSHCS, S_PUSHIP,
    S_RDIP, S_RDCS, S_EDONE, S_POPIP, S_POPCS, S_POPF, S_RDONE
  } state_e;

  state_e state, nxt;
  logic nmiPrev, nmiPend, nmiTake;
  logic evalAll, evalAny;
  logic takeDiv, takeOvf, takeSw, takeNmi, takeIntr, takeStep;

  assign evalAll  = bndry && !haltIn;
  assign evalAny  = evalAll || haltIn;
  assign takeDiv  = evalAll && divErr;
  assign takeOvf  = evalAll && intoExec && flagOf;
  assign takeSw   = evalAll && swReq;
  assign takeNmi  = evalAny && nmiPend;
  assign takeIntr = evalAny && intrPin && flagIf;
  assign takeStep = evalAll && flagTf;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      nmiPrev <= nmiPin;
      nmiPend <= 1'b0;
    end else begin
      state   <= nxt;
      nmiPrev <= nmiPin;
      nmiPend <= (nmiPend && !nmiTake) || (nmiPin && !nmiPrev);
    end
  end

  always_comb begin
    nxt       = state;
    st        = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    intaN     = 1'b1;
    entryDone = 1'b0;
    retDone   = 1'b0;
    nmiTake   = 1'b0;
    busy      = (state != S_IDLE);
    case (state)
      S_IDLE: begin
        if (iretReq) begin
          st.capCtx = 1'b1;
          nxt       = S_POPIP;
        end else if (takeDiv || takeOvf || takeSw || takeNmi || takeIntr || takeStep) begin
          st.capCtx = 1'b1;
          st.ldType = 1'b1;
          nxt       = S_PUSHF;
          if (takeDiv)       st.typeVal = TYPE_DIV;
          else if (takeOvf)  st.typeVal = TYPE_OVF;
          else if (takeSw)   st.typeVal = swType;
          else if (takeNmi) begin
            st.typeVal = TYPE_NMI;
            nmiTake    = 1'b1;
          end else if (takeIntr) begin
            st.ldType = 1'b0;
            nxt       = S_INTA1;
          end else           st.typeVal = TYPE_STEP;
        end
      end
      S_INTA1: begin intaN = 1'b0; nxt = S_GAP; end
      S_GAP:   nxt = S_INTA2;
      S_INTA2: begin intaN = 1'b0; st.capBus = 1'b1; nxt = S_PUSHF; end
      S_PUSHF, S_PUSHCS, S_PUSHIP: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        st.addrSel = A_PUSH;
        st.wdSel   = (state == S_PUSHF) ? W_FLAGS : (state == S_PUSHCS) ? W_CS : W_IP;
        if (memAck) begin
          st.spDown = 1'b1;
          nxt = (state == S_PUSHF) ? S_PUSHCS : (state == S_PUSHCS) ? S_PUSHIP : S_RDIP;
        end
      end
      S_RDIP, S_RDCS: begin
        memReq     = 1'b1;
        st.addrSel = (state == S_RDIP) ? A_VLO : A_VHI;
        if (memAck) begin
          st.ldIp = (state == S_RDIP);
          st.ldCs = (state == S_RDCS);
          nxt     = (state == S_RDIP) ? S_RDCS : S_EDONE;
        end
      end
      S_EDONE: begin entryDone = 1'b1; nxt = S_IDLE; end
      S_POPIP, S_POPCS, S_POPF: begin
        memReq     = 1'b1;
        st.addrSel = A_POP;
        if (memAck) begin
          st.spUp    = 1'b1;
          st.ldIp    = (state == S_POPIP);
          st.ldCs    = (state == S_POPCS);
          st.ldFlags = (state == S_POPF);
          nxt = (state == S_POPIP) ? S_POPCS : (state == S_POPCS) ? S_POPF : S_RDONE;
        end
      end
      S_RDONE: begin retDone = 1'b1; nxt = S_IDLE; end
      default: nxt = S_IDLE;
    endcase
  end

  p_nmi_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (nmiPin && !nmiPrev) |=> nmiPend);
  p_inta_width_r5: assert property (@(posedge clk) disable iff (rst)
    !intaN |=> intaN);
  p_inta_no_mem_r5: assert property (@(posedge clk) disable iff (rst)
    !intaN |-> !memReq);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));
  p_one_done_r11: assert property (@(posedge clk) disable iff (rst)
    !(entryDone && retDone));
endmodule

// File: rtl/irq_dp.sv
module irq_dp
  import irq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         st,
  input  logic              memReq,
  input  logic              memAck,
  input  logic [DW-1:0]     memRdata,
  input  logic [DW-1:0]     ssIn,
  input  logic [DW-1:0]     spIn,
  input  logic [DW-1:0]     csIn,
  input  logic [DW-1:0]     ipIn,
  input  logic [DW-1:0]     flagsIn,
  input  logic [TYPE_W-1:0] typeBus,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memWdata,
  output logic [TYPE_W-1:0] typeOut,
  output logic [DW-1:0]     newCs,
  output logic [DW-1:0]     newIp,
  output logic [DW-1:0]     newSp,
  output logic [DW-1:0]     newFlags
);
  localparam int SEG = AW - DW;
  localparam int VPAD = AW - TYPE_W - 2;
  localparam logic [DW-1:0] STEP = DW'(2);
  localparam logic [DW-1:0] CLR_MASK = ~((DW'(1) << IF_POS) | (DW'(1) << TF_POS));

  logic [DW-1:0] ssR, spR, csR, ipR, flagsSave;
  logic [AW-1:0] segBase, vecBase;

  assign segBase = {ssR, {SEG{1'b0}}};
  assign vecBase = {{VPAD{1'b0}}, typeOut, 2'b00};

  always_comb begin
    case (st.addrSel)
      A_PUSH:  memAddr = segBase + {{SEG{1'b0}}, spR - STEP};
      A_POP:   memAddr = segBase + {{SEG{1'b0}}, spR};
      A_VLO:   memAddr = vecBase;
      default: memAddr = vecBase + AW'(2);
    endcase
    case (st.wdSel)
      W_FLAGS: memWdata = flagsSave;
      W_CS:    memWdata = csR;
      default: memWdata = ipR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ssR <= '0; spR <= '0; csR <= '0; ipR <= '0; flagsSave <= '0;
      typeOut <= '0; newCs <= '0; newIp <= '0; newFlags <= '0;
    end else begin
      if (st.capCtx) begin
        ssR       <= ssIn;
        spR       <= spIn;
        csR       <= csIn;
        ipR       <= ipIn;
        flagsSave <= flagsIn;
        newFlags  <= flagsIn & CLR_MASK;
      end
      if (st.ldType)  typeOut <= st.typeVal;
      if (st.capBus)  typeOut <= typeBus;
      if (st.spDown)  spR <= spR - STEP;
      if (st.spUp)    spR <= spR + STEP;
      if (st.ldIp)    newIp <= memRdata;
      if (st.ldCs)    newCs <= memRdata;
      if (st.ldFlags) newFlags <= memRdata;
    end
  end

  assign newSp = spR;

  p_sp_push_r9: assert property (@(posedge clk) disable iff (rst)
    (memReq && memAck && st.addrSel == A_PUSH) |=> (spR == $past(spR) - STEP));
  p_sp_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (memReq && memAck && st.addrSel == A_POP) |=> (spR == $past(spR) + STEP));
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWdata)));
  p_vec_range_r6: assert property (@(posedge clk) disable iff (rst)
    (memReq && st.addrSel == A_VLO) |-> (memAddr[1:0] == 2'b00 && memAddr[AW-1:10] == '0));
  p_clr_flags_r7: assert property (@(posedge clk) disable iff (rst)
    st.capCtx |=> (!newFlags[IF_POS] && !newFlags[TF_POS]));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bndry,
  input  logic              haltIn,
  input  logic              iretReq,
  input  logic              nmiPin,
  input  logic              intrPin,
  input  logic              divErr,
  input  logic              intoExec,
  input  logic              swReq,
  input  logic [TYPE_W-1:0] swType,
  input  logic [DW-1:0]     flagsIn,
  input  logic [DW-1:0]     ssIn,
  input  logic [DW-1:0]     spIn,
  input  logic [DW-1:0]     csIn,
  input  logic [DW-1:0]     ipIn,
  input  logic [TYPE_W-1:0] typeBus,
  output logic              intaN,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memWdata,
  input  logic              memAck,
  input  logic [DW-1:0]     memRdata,
  output logic              busy,
  output logic              entryDone,
  output logic              retDone,
  output logic [TYPE_W-1:0] typeOut,
  output logic [DW-1:0]     newCs,
  output logic [DW-1:0]     newIp,
  output logic [DW-1:0]     newSp,
  output logic [DW-1:0]     newFlags
);
  dpStrobe_t st;

  irq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .bndry(bndry), .haltIn(haltIn), .iretReq(iretReq),
    .nmiPin(nmiPin), .intrPin(intrPin), .divErr(divErr), .intoExec(intoExec),
    .swReq(swReq), .swType(swType),
    .flagIf(flagsIn[IF_POS]), .flagTf(flagsIn[TF_POS]), .flagOf(flagsIn[OF_POS]),
    .memAck(memAck), .memReq(memReq), .memWe(memWe), .intaN(intaN), .busy(busy),
    .entryDone(entryDone), .retDone(retDone), .st(st)
  );

  irq_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .st(st), .memReq(memReq), .memAck(memAck),
    .memRdata(memRdata), .ssIn(ssIn), .spIn(spIn), .csIn(csIn), .ipIn(ipIn),
    .flagsIn(flagsIn), .typeBus(typeBus), .memAddr(memAddr), .memWdata(memWdata),
    .typeOut(typeOut), .newCs(newCs), .newIp(newIp), .newSp(newSp), .newFlags(newFlags)
  );
endmodule

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bndry = 0, haltIn = 0, iretReq = 0, nmiPin = 0, intrPin = 0;
  logic divErr = 0, intoExec = 0, swReq = 0;
  logic [7:0] swType = 0, typeBus = 0;
  logic [15:0] flagsIn = 0, ssIn = 0, spIn = 0, csIn = 0, ipIn = 0;
  logic memAck = 0;
  logic [15:0] memRdata = 0;
  logic intaN, memReq, memWe, busy, entryDone, retDone;
  logic [19:0] memAddr;
  logic [15:0] memWdata, newCs, newIp, newSp, newFlags;
  logic [7:0] typeOut;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst(rst), .bndry(bndry), .haltIn(haltIn), .iretReq(iretReq),
    .nmiPin(nmiPin), .intrPin(intrPin), .divErr(divErr), .intoExec(intoExec),
    .swReq(swReq), .swType(swType), .flagsIn(flagsIn), .ssIn(ssIn), .spIn(spIn),
    .csIn(csIn), .ipIn(ipIn), .typeBus(typeBus), .intaN(intaN), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .busy(busy), .entryDone(entryDone), .retDone(retDone),
    .typeOut(typeOut), .newCs(newCs), .newIp(newIp), .newSp(newSp), .newFlags(newFlags)
  );

  always #2.5 clk = ~clk;

  int nTests = 0, nFail = 0;
  logic [19:0] logAddr [0:7];
  logic        logWe   [0:7];
  logic [15:0] logData [0:7];
  int logN = 0, intaCnt = 0, widthErr = 0, stallErr = 0, waitCnt = 0;
  logic inReq = 0, prevLow = 0;
  logic [19:0] startAddr = 0;
  logic [7:0] busT = 0;
  logic nmiPendM = 0;

  function automatic logic [15:0] rdFn(input logic [19:0] a);
    return a[15:0] * 16'h9E37 ^ 16'h5A5A ^ {12'h0, a[19:16]};
  endfunction
  function automatic logic [19:0] stkAddr(input logic [15:0] ss, input logic [15:0] sp, input int delta);
    logic [15:0] p;
    p = sp + 16'(delta);
    return {ss, 4'h0} + {4'h0, p};
  endfunction
  // {take, isIntr, type}
  function automatic logic [9:0] pick(input logic dv, input logic io, input logic [15:0] f,
      input logic sw, input logic [7:0] st, input logic nm, input logic ir,
      input logic hl, input logic bd);
    logic all, any;
    all = bd && !hl;
    any = all || hl;
    if (all && dv)               return {2'b10, 8'd0};
    if (all && io && f[11])      return {2'b10, 8'd4};
    if (all && sw)               return {2'b10, st};
    if (any && nm)               return {2'b10, 8'd2};
    if (any && ir && f[9])       return {2'b11, 8'd0};
    if (all && f[8])             return {2'b10, 8'd1};
    return 10'd0;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory and acknowledge responder
  initial begin
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (!intaN) begin
        if (prevLow) widthErr++;
        intaCnt++;
      end
      prevLow = !intaN;
      typeBus = (!intaN && intaCnt == 2) ? busT : ~busT;
      if (memReq) begin
        if (!inReq) begin
          inReq = 1'b1;
          startAddr = memAddr;
          waitCnt = int'($urandom % 3);
        end
        if (waitCnt == 0) begin
          if (memAddr != startAddr) stallErr++;
          memAck = 1'b1;
          memRdata = rdFn(memAddr);
          if (logN < 8) begin
            logAddr[logN] = memAddr; logWe[logN] = memWe; logData[logN] = memWdata;
          end
          logN++;
          inReq = 1'b0;
        end else waitCnt--;
      end
    end
  end

  task automatic prep();
    logN = 0; intaCnt = 0;
    ssIn = 16'($urandom); spIn = 16'($urandom); csIn = 16'($urandom); ipIn = 16'($urandom);
    busT = 8'($urandom);
  endtask

  task automatic clearIn();
    bndry = 0; haltIn = 0; iretReq = 0; divErr = 0; intoExec = 0; swReq = 0;
  endtask

  task automatic pulseNmi();
    nmiPin = 1; @(negedge clk); nmiPin = 0; @(negedge clk);
    nmiPendM = 1;
  endtask

  // called at a negedge after the inputs of the decision cycle are applied
  task automatic finish(input string tag, input logic [9:0] w);
    logic [15:0] f, ss, sp, cs, ip;
    logic [7:0] t;
    f = flagsIn; ss = ssIn; sp = spIn; cs = csIn; ip = ipIn;
    @(negedge clk);
    clearIn();
    if (!w[9]) begin
      repeat (5) @(negedge clk);
      intrPin = 0;
      check(!busy && logN == 0 && intaCnt == 0, {tag, " no entry"}, {busy, 7'd0, 24'(logN)}, 0);
      return;
    end
    t = w[8] ? busT : w[7:0];
    if (!w[8] && w[7:0] == 8'd2) nmiPendM = 0;
    for (int k = 0; k < 300 && !entryDone; k++) @(negedge clk);
    intrPin = 0;
    check(entryDone, {tag, " done"}, 32'(entryDone), 1);
    check(typeOut == t, {tag, " type"}, 32'(typeOut), 32'(t));
    check(intaCnt == (w[8] ? 2 : 0), "R5 inta pulse count", 32'(intaCnt), w[8] ? 2 : 0);
    check(logN == 5, "R7 access count", 32'(logN), 5);
    check(logWe[0] && logAddr[0] == stkAddr(ss, sp, -2) && logData[0] == f, "R7 R9 push flags",
          {logWe[0], logAddr[0], 11'd0}, {1'b1, stkAddr(ss, sp, -2), 11'd0});
    check(logWe[1] && logAddr[1] == stkAddr(ss, sp, -4) && logData[1] == cs, "R7 R9 push cs",
          32'(logData[1]), 32'(cs));
    check(logWe[2] && logAddr[2] == stkAddr(ss, sp, -6) && logData[2] == ip, "R7 R9 push ip",
          32'(logData[2]), 32'(ip));
    check(!logWe[3] && logAddr[3] == {10'd0, t, 2'b00}, "R6 vector ip addr",
          32'(logAddr[3]), 32'({10'd0, t, 2'b00}));
    check(!logWe[4] && logAddr[4] == {10'd0, t, 2'b00} + 20'd2, "R6 vector cs addr",
          32'(logAddr[4]), 32'({10'd0, t, 2'b00} + 20'd2));
    check(newIp == rdFn({10'd0, t, 2'b00}) && newCs == rdFn({10'd0, t, 2'b00} + 20'd2),
          "R6 new cs:ip", {newCs, newIp}, {rdFn({10'd0, t, 2'b00} + 20'd2), rdFn({10'd0, t, 2'b00})});
    check(newSp == sp - 16'd6, "R9 new sp", 32'(newSp), 32'(sp - 16'd6));
    check(newFlags == (f & 16'hFCFF), "R7 flags cleared", 32'(newFlags), 32'(f & 16'hFCFF));
    @(negedge clk);
  endtask

  task automatic runRet();
    logic [15:0] ss, sp;
    prep();
    ss = ssIn; sp = spIn;
    iretReq = 1; bndry = 1; flagsIn = 16'h0100;
    @(negedge clk);
    clearIn();
    for (int k = 0; k < 300 && !retDone; k++) @(negedge clk);
    check(retDone && !entryDone, "R11 return done", 32'(retDone), 1);
    check(logN == 3 && !logWe[0] && !logWe[1] && !logWe[2], "R11 three reads", 32'(logN), 3);
    check(logAddr[0] == stkAddr(ss, sp, 0) && logAddr[1] == stkAddr(ss, sp, 2) &&
          logAddr[2] == stkAddr(ss, sp, 4), "R11 R9 pop addresses", 32'(logAddr[2]), 32'(stkAddr(ss, sp, 4)));
    check(newIp == rdFn(stkAddr(ss, sp, 0)) && newCs == rdFn(stkAddr(ss, sp, 2)) &&
          newFlags == rdFn(stkAddr(ss, sp, 4)), "R11 restored values", {newCs, newIp},
          {rdFn(stkAddr(ss, sp, 2)), rdFn(stkAddr(ss, sp, 0))});
    check(newSp == sp + 16'd6, "R11 R9 sp+6", 32'(newSp), 32'(sp + 16'd6));
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20571));
    repeat (3) @(negedge clk);
    check(!busy && !memReq && intaN && !entryDone && !retDone, "R1 in reset",
          {busy, memReq, intaN, entryDone, retDone}, 5'b00100);
    rst = 0;
    @(negedge clk);
    check(!busy && !memReq && intaN && !entryDone && !retDone, "R1 after reset",
          {busy, memReq, intaN, entryDone, retDone}, 5'b00100);

    // R2: divide beats everything
    prep(); flagsIn = 16'h0B00; divErr = 1; intoExec = 1; swReq = 1; swType = 8'h21;
    intrPin = 1; bndry = 1;
    finish("R2 divide wins", pick(1, 1, flagsIn, 1, 8'h21, 0, 1, 0, 1));
    // R8: INTO without overflow does nothing
    prep(); flagsIn = 16'h0000; intoExec = 1; bndry = 1;
    finish("R8 into no overflow", pick(0, 1, flagsIn, 0, 0, 0, 0, 0, 1));
    prep(); flagsIn = 16'h0800; intoExec = 1; swReq = 1; swType = 8'h80; bndry = 1;
    finish("R8 into overflow", pick(0, 1, flagsIn, 1, 8'h80, 0, 0, 0, 1));
    // R4: masked INTR ignored, INTR without boundary ignored
    prep(); flagsIn = 16'h0000; intrPin = 1; bndry = 1;
    finish("R4 masked intr", 10'd0);
    prep(); flagsIn = 16'h0200; intrPin = 1; bndry = 0;
    finish("R4 intr off boundary", 10'd0);
    prep(); flagsIn = 16'h0300; intrPin = 1; bndry = 1;
    finish("R4 R5 intr taken", pick(0, 0, flagsIn, 0, 0, 0, 1, 0, 1));
    // R3: NMI ignores IF, re-latched during a sequence
    pulseNmi();
    prep(); flagsIn = 16'h0000; bndry = 1;
    finish("R3 nmi masked flags", pick(0, 0, flagsIn, 0, 0, 1, 0, 0, 1));
    prep(); flagsIn = 16'h0000; bndry = 1;
    finish("R3 nmi latch cleared", 10'd0);
    prep(); flagsIn = 16'h0000; swReq = 1; swType = 8'h13; bndry = 1;
    @(negedge clk); clearIn(); @(negedge clk);
    nmiPin = 1; @(negedge clk); nmiPin = 0;
    for (int k = 0; k < 300 && !entryDone; k++) @(negedge clk);
    @(negedge clk);
    prep(); flagsIn = 16'h0000; bndry = 1;
    finish("R3 nmi during isr", {2'b10, 8'd2});
    // R12: halted core
    prep(); flagsIn = 16'h0900; swReq = 1; divErr = 1; intoExec = 1; haltIn = 1; bndry = 1;
    finish("R12 halt ignores internal", 10'd0);
    prep(); flagsIn = 16'h0200; intrPin = 1; haltIn = 1;
    finish("R12 halt wake intr", {2'b11, 8'd0});
    // R8: trace
    prep(); flagsIn = 16'h0100; bndry = 1;
    finish("R8 trace", {2'b10, 8'd1});
    // R11
    runRet();

    for (int i = 0; i < 40; i++) begin
      logic dv, io, sw, ir, hl, nw;
      logic [7:0] stp;
      dv = ($urandom % 6) == 0; io = ($urandom % 4) == 0; sw = ($urandom % 4) == 0;
      ir = ($urandom % 3) == 0; hl = ($urandom % 8) == 0; nw = ($urandom % 4) == 0;
      stp = 8'($urandom);
      if (nw) pulseNmi();
      prep();
      flagsIn = 16'($urandom) & 16'h0F00;
      divErr = dv; intoExec = io; swReq = sw; swType = stp; intrPin = ir; haltIn = hl; bndry = 1;
      finish("R2 random mix", pick(dv, io, flagsIn, sw, stp, nmiPendM, ir, hl, 1));
      if (i % 8 == 0) runRet();
    end

    check(widthErr == 0, "R5 pulse width", 32'(widthErr), 0);
    check(stallErr == 0, "R10 held during stall", 32'(stallErr), 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule